// File: doc/BRIEF.md
# I2C Bus-Busy Tracker with Recovery

This block watches the two wires of a multi-master I2C bus and keeps a bus-busy flag. A START condition (SDA falling while SCL is high) sets the flag and a STOP condition (SDA rising while SCL is high) clears it. Both wires pass through a synchronizer before any edge is detected. The block also sits between the controller's byte engine and the open-drain pads. The engine's pull-low requests for SDA and SCL reach the pad enables only while the block is enabled and no arbitration lockout is in force.

When the engine reports lost arbitration, both pull-low enables are released in that same cycle. They stay released until the engine asks for a new transfer while the bus is idle. The busy flag still follows only the wires. If no STOP ever arrives, the flag stays set and the controller stays out of the bus. Software uses the busy flag to start its own timeout. Driving the module enable low is the one way to force the flag clear and release the pads. Raising the enable again resumes normal tracking.

All pins are plain control and status signals. No data stream crosses this block, so it has no valid/ready handshake and no back-pressure.

Top module: `i2c_busy_guard`

## Requirements
- R1: After reset, bus_busy is 0 and both sda_pull_oe and scl_pull_oe are 0.
- R2: With enable high, SDA going 1 to 0 while SCL stays 1 sets bus_busy. The flag appears on the third rising clock edge after the change, with SYNC_STAGES=2.
- R3: With enable high, SDA going 0 to 1 while SCL stays 1 clears bus_busy, with the same latency as R2.
- R4: Changes on SDA while SCL is 0 do not change bus_busy.
- R5: While enabled and not locked out, sda_pull_oe equals sda_pull_req and scl_pull_oe equals scl_pull_req in the same cycle, with no register in the path.
- R6: In the cycle where arb_lost is 1 with enable high, both pull-low enables are 0. Both remain 0 from the next cycle on, while the lockout holds.
- R7: After arbitration loss, bus_busy stays 1 until a STOP is seen on the wires. The pull-low enables stay 0 while the bus is busy, even with requests asserted.
- R8: The lockout ends at the first rising edge where a pull-low request is asserted and bus_busy is 0. From the following cycle, the enables follow the requests again.
- R9: While enable is 0, both pull-low enables are 0 in the same cycle. bus_busy is 0 from the next rising edge. START and STOP conditions on the wires are ignored.
- R10: After enable returns to 1 with idle wires, START and STOP detection and request pass-through work again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mod_en | input | 1 | Module enable; low aborts bus tracking and releases the pads |
| sda_in | input | 1 | Sampled SDA wire level |
| scl_in | input | 1 | Sampled SCL wire level |
| arb_lost | input | 1 | One-cycle arbitration-lost pulse from the byte engine |
| sda_pull_req | input | 1 | Engine request to pull SDA low |
| scl_pull_req | input | 1 | Engine request to pull SCL low |
| bus_busy | output | 1 | Bus-busy flag: set by START, cleared by STOP or disable |
| sda_pull_oe | output | 1 | Gated open-drain enable for SDA |
| scl_pull_oe | output | 1 | Gated open-drain enable for SCL |

## Verification
The bench builds the block with its default SYNC_STAGES=2, so every wire change reaches bus_busy in a short, known number of edges. It sweeps all four request combinations for each enable level and for the locked and unlocked states. It walks the wires through every START, STOP and SCL-low toggle ordering. The small synchronizer depth keeps the exact cycle of lockout entry and exit within reach. The same holds for the clear on disable and the resume on re-enable.

// File: rtl/i2c_bg_pkg.sv
package i2c_bg_pkg;
  localparam int LINE_CNT = 2;
  localparam int LN_SCL   = 0;
  localparam int LN_SDA   = 1;

  typedef struct packed {
    logic sda;
    logic scl;
  } bg_lines_t;

  typedef enum logic {
    BG_IDLE = 1'b0,
    BG_BUSY = 1'b1
  } bg_state_e;
endpackage

// File: rtl/bg_sync.sv
module bg_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam int TOP = STAGES - 1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   chain <= '1;
      else if (!en) chain <= '1;
      else          chain <= {chain[STAGES-2:0], d[i]};
    end
    assign q[i] = chain[TOP];
  end
endmodule

// File: rtl/bg_cond_detect.sv
module bg_cond_detect
  import i2c_bg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  input  bg_lines_t lines,
  output logic      start_det,
  output logic      stop_det
);
  bg_lines_t prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   prev_q <= '{sda: 1'b1, scl: 1'b1};
    else if (!en) prev_q <= '{sda: 1'b1, scl: 1'b1};
    else          prev_q <= lines;
  end

  logic scl_steady_hi;
  assign scl_steady_hi = lines.scl & prev_q.scl;
  assign start_det = en & scl_steady_hi &  prev_q.sda & ~lines.sda;
  assign stop_det  = en & scl_steady_hi & ~prev_q.sda &  lines.sda;
endmodule

// File: rtl/bg_busy_track.sv
module bg_busy_track
  import i2c_bg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic start_det,
  input  logic stop_det,
  output logic busy
);
  bg_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      BG_IDLE: if (start_det) state_d = BG_BUSY;
      BG_BUSY: if (stop_det)  state_d = BG_IDLE;
      default: state_d = BG_IDLE;
    endcase
    if (!en) state_d = BG_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= BG_IDLE;
    else        state_q <= state_d;
  end

  assign busy = (state_q == BG_BUSY);

  // R2
  start_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && start_det) |=> busy);
  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && busy && !stop_det) |=> busy);
  // R9
  dis_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en) |=> !busy);
endmodule

// File: rtl/bg_drive_gate.sv
module bg_drive_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic arb_lost,
  input  logic busy,
  input  logic sda_req,
  input  logic scl_req,
  output logic sda_oe,
  output logic scl_oe
);
  logic lockout_q;
  logic any_req;

  assign any_req = sda_req | scl_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   lockout_q <= 1'b0;
    else if (!en)                 lockout_q <= 1'b0;
    else if (arb_lost)            lockout_q <= 1'b1;
    else if (any_req && !busy)    lockout_q <= 1'b0;
  end

  logic pass;
  assign pass   = en & ~arb_lost & ~lockout_q;
  assign sda_oe = pass & sda_req;
  assign scl_oe = pass & scl_req;

  // R6
  arb_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && arb_lost) |=> (!sda_oe && !scl_oe));
  // R7
  busy_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lockout_q && busy && en && !arb_lost) |=> (!sda_oe && !scl_oe) || !busy);
  // R9
  dis_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en) |-> (!sda_oe && !scl_oe));
endmodule

// File: rtl/i2c_busy_guard.sv
module i2c_busy_guard
  import i2c_bg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mod_en,
  input  logic sda_in,
  input  logic scl_in,
  input  logic arb_lost,
  input  logic sda_pull_req,
  input  logic scl_pull_req,
  output logic bus_busy,
  output logic sda_pull_oe,
  output logic scl_pull_oe
);
  logic [LINE_CNT-1:0] raw_lines, syn_lines;
  bg_lines_t           lines;
  logic                start_det, stop_det;

  assign raw_lines[LN_SDA] = sda_in;
  assign raw_lines[LN_SCL] = scl_in;

  bg_sync #(.STAGES(SYNC_STAGES), .WIDTH(LINE_CNT)) sync_i (
    .clk(clk), .rst_n(rst_n), .en(mod_en), .d(raw_lines), .q(syn_lines)
  );

  assign lines.sda = syn_lines[LN_SDA];
  assign lines.scl = syn_lines[LN_SCL];

  bg_cond_detect detect_i (
    .clk(clk), .rst_n(rst_n), .en(mod_en), .lines(lines),
    .start_det(start_det), .stop_det(stop_det)
  );

  bg_busy_track track_i (
    .clk(clk), .rst_n(rst_n), .en(mod_en),
    .start_det(start_det), .stop_det(stop_det), .busy(bus_busy)
  );

  bg_drive_gate gate_i (
    .clk(clk), .rst_n(rst_n), .en(mod_en), .arb_lost(arb_lost),
    .busy(bus_busy), .sda_req(sda_pull_req), .scl_req(scl_pull_req),
    .sda_oe(sda_pull_oe), .scl_oe(scl_pull_oe)
  );
endmodule

// File: tb/i2c_busy_guard_tb_top.sv
module i2c_busy_guard_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mod_en = 1'b0, sda_in = 1'b1, scl_in = 1'b1, arb_lost = 1'b0;
  logic sda_pull_req = 1'b0, scl_pull_req = 1'b0;
  logic bus_busy, sda_pull_oe, scl_pull_oe;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  i2c_busy_guard #(.SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .sda_in(sda_in),
    .scl_in(scl_in), .arb_lost(arb_lost), .sda_pull_req(sda_pull_req),
    .scl_pull_req(scl_pull_req), .bus_busy(bus_busy),
    .sda_pull_oe(sda_pull_oe), .scl_pull_oe(scl_pull_oe)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  function automatic int oe_pair();
    return {sda_pull_oe, scl_pull_oe};
  endfunction

  task automatic set_lines(input logic sda, input logic scl);
    @(negedge clk);
    sda_in = sda; scl_in = scl;
    tick(5);
  endtask

  task automatic set_req(input int r);
    @(negedge clk);
    sda_pull_req = r[1]; scl_pull_req = r[0];
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(3);
    // R1 reset state
    chk("R1 busy", bus_busy, 0);
    chk("R1 oe", oe_pair(), 0);
    rst_n = 1'b1;
    mod_en = 1'b1;
    tick(3);

    // R5 pass-through sweep, unlocked
    for (int r = 0; r < 4; r++) begin
      set_req(r);
      chk("R5 pass", oe_pair(), r);
    end
    set_req(0);

    // R2 START with exact latency
    @(negedge clk); sda_in = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    chk("R2 not yet", bus_busy, 0);
    @(posedge clk); #1;
    chk("R2 start", bus_busy, 1);

    // R4 SDA toggles with SCL low
    set_lines(1'b0, 1'b0);
    set_lines(1'b1, 1'b0);
    chk("R4 sda up scl low", bus_busy, 1);
    set_lines(1'b0, 1'b0);
    chk("R4 sda down scl low", bus_busy, 1);

    // R3 STOP
    set_lines(1'b0, 1'b1);
    chk("R3 pre", bus_busy, 1);
    set_lines(1'b1, 1'b1);
    chk("R3 stop", bus_busy, 0);

    // R4 from idle: SCL low, SDA toggle, no START seen
    set_lines(1'b1, 1'b0);
    set_lines(1'b0, 1'b0);
    chk("R4 idle", bus_busy, 0);
    set_lines(1'b1, 1'b0);
    set_lines(1'b1, 1'b1);
    chk("R4 idle end", bus_busy, 0);

    // R6 / R7 arbitration loss mid-transfer
    set_lines(1'b0, 1'b1);
    set_req(3);
    chk("R5 busy pass", oe_pair(), 3);
    @(negedge clk); arb_lost = 1'b1; #1;
    chk("R6 same cycle", oe_pair(), 0);
    @(negedge clk); arb_lost = 1'b0; #1;
    chk("R6 next cycle", oe_pair(), 0);
    for (int r = 0; r < 4; r++) begin
      set_req(r);
      tick(2);
      chk("R7 locked oe", oe_pair(), 0);
      chk("R7 busy held", bus_busy, 1);
    end
    set_lines(1'b0, 1'b0);
    set_lines(1'b1, 1'b0);
    chk("R7 no stop", bus_busy, 1);
    chk("R7 no stop oe", oe_pair(), 0);
    set_lines(1'b0, 1'b0);
    set_lines(1'b0, 1'b1);
    set_lines(1'b1, 1'b1);
    chk("R7 stop frees", bus_busy, 0);
    // R8 req=3 still held, idle -> lockout gone
    chk("R8 after stop", oe_pair(), 3);

    // R8 exact exit timing with idle bus
    set_req(0);
    @(negedge clk); arb_lost = 1'b1;
    @(negedge clk); arb_lost = 1'b0;
    tick(2);
    set_req(2);
    chk("R8 first cycle", oe_pair(), 0);
    tick(1);
    chk("R8 next cycle", oe_pair(), 2);
    set_req(0);

    // R9 disable while busy and locked
    set_lines(1'b0, 1'b1);
    set_req(3);
    @(negedge clk); arb_lost = 1'b1;
    @(negedge clk); arb_lost = 1'b0;
    chk("R9 pre busy", bus_busy, 1);
    @(negedge clk); mod_en = 1'b0; #1;
    chk("R9 oe now", oe_pair(), 0);
    tick(1);
    chk("R9 busy clr", bus_busy, 0);
    for (int r = 0; r < 4; r++) begin
      set_req(r);
      chk("R9 sweep", oe_pair(), 0);
    end
    set_lines(1'b1, 1'b1);
    set_lines(1'b0, 1'b1);
    chk("R9 start ignored", bus_busy, 0);
    set_lines(1'b1, 1'b1);
    chk("R9 idle", bus_busy, 0);

    // R10 resume
    set_req(0);
    @(negedge clk); mod_en = 1'b1;
    tick(3);
    chk("R10 idle after en", bus_busy, 0);
    for (int r = 0; r < 4; r++) begin
      set_req(r);
      chk("R10 pass", oe_pair(), r);
    end
    set_req(0);
    set_lines(1'b0, 1'b1);
    chk("R10 start", bus_busy, 1);
    set_lines(1'b1, 1'b1);
    chk("R10 stop", bus_busy, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule